// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block settles the result of a two-operand floating-point operation when one or both operands are NaN. It sits beside an arithmetic datapath. The datapath sends it the raw operands together with a policy code. One clock later the block returns three things: the NaN that the operation must produce, a flag that says whether any operand was NaN, and the invalid-operation flag. The operand format is fixed at elaboration, either binary32 or binary64. The polarity of the quiet bit is also a parameter, so a design can treat a set quiet bit as meaning either quiet or signalling.

Three policies can be chosen per operation:

- **Magnitude-select.** The NaN operand is preferred. Among NaNs of the same kind, the larger significand wins, and a sign-based tie-break settles equal significands.
- **Signalling-replace.** A quiet NaN is passed through, but a signalling NaN that would be returned is replaced by the canonical default NaN.
- **Always-default.** Any NaN input produces the canonical default NaN.

Top module: `nanprop_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its significand is non-zero. `nan_present` is high exactly when at least one operand is a NaN. When neither operand is a NaN, `result` is zero and `invalid` is low.
- R2: `invalid` is high whenever either operand is a signalling NaN, under every mode and whichever operand is returned.
- R3: When exactly one operand is a NaN and it is quiet, that operand is returned unchanged in mode 0 and in mode 1.
- R4: In mode 0 or mode 1, when one operand is a signalling NaN and the other is a quiet NaN, the quiet NaN is returned unchanged.
- R5: In mode 0, when both operands are NaNs of the same kind, the result is built from the operand whose bit pattern, with the sign bit shifted out, is larger.
- R6: When the patterns compared under R5 are equal, the operand with the smaller raw pattern is chosen, which is the positive one. Identical operands return that value.
- R7: With the quiet bit meaning quiet (QUIET_IS_ONE=1), mode 0 quiets a signalling NaN it returns by setting significand bit 22 (binary32) or bit 51 (binary64).
- R8: With the quiet bit meaning signalling (QUIET_IS_ONE=0), mode 0 quiets a returned signalling NaN by clearing that bit. If the remaining significand would then be zero, the default NaN is returned instead.
- R9: Mode codes are: 0 magnitude-select, 1 signalling-replace, 2 and 3 always-default. In modes 2 and 3, any NaN input gives the default NaN. The default NaN has sign 0 and exponent all ones. Its significand is only the quiet bit when QUIET_IS_ONE=1 (binary32 0x7FC00000), or all bits below the quiet bit when QUIET_IS_ONE=0.
- R10: In mode 1, a signalling NaN that the selection would return is replaced by the default NaN.
- R11: Outputs are registered. `valid_out` follows `valid_in` one cycle later, and `result`, `nan_present` and `invalid` load only on cycles with `valid_in` high and hold otherwise. A synchronous active-low reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Operands and mode are valid this cycle |
| mode_in | input | 2 | Propagation policy code (R9) |
| op_a | input | W | First operand (W = 32 or 64) |
| op_b | input | W | Second operand |
| valid_out | output | 1 | Registered outputs are valid |
| result | output | W | Selected or default NaN, zero when no NaN |
| nan_present | output | 1 | At least one operand was NaN |
| invalid | output | 1 | At least one operand was a signalling NaN |

## Verification
Raising `invalid` and replacing or quieting the returned NaN fall in the same cycle whenever a signalling NaN is present. The interesting cases are those where the flag rises but the returned value comes from the other, quiet operand, and those where the returned signalling NaN's significand would vanish on quieting. The sweep provokes both in every mode by pairing each class with each other class under several significand and sign patterns, including a zero payload, equal significands of opposite sign, and identical operands. In every case the flag and the value are judged separately against a model computed in the bench. Two instances cover the two formats and the two quiet-bit polarities.

// File: rtl/nanprop_pkg.sv
// Package: shared mode codes and format helpers for the NaN propagation unit.
// Assumes only binary32 or binary64 encodings are requested.
package nanprop_pkg;

    // Policy applied when a NaN operand is present.
    typedef enum logic [1:0] {
        NP_MODE_MAGSEL   = 2'd0,
        NP_MODE_SNAN_DEF = 2'd1,
        NP_MODE_DEF      = 2'd2,
        NP_MODE_DEF_ALT  = 2'd3
    } np_mode_e;

    // Total width of the chosen format.
    function automatic int fmt_width(input bit is_double);
        return is_double ? 64 : 32;
    endfunction

    // Exponent field width of the chosen format.
    function automatic int fmt_exp_width(input bit is_double);
        return is_double ? 11 : 8;
    endfunction

endpackage

// File: rtl/nanprop_classify.sv
// Module: nanprop_classify
// Classes one operand as NaN, quiet NaN or signalling NaN.
// Assumes the quiet bit is the top significand bit and its polarity is
// given by QUIET_IS_ONE.
module nanprop_classify #(
    parameter int W            = 32,
    parameter int EXP_W        = 8,
    parameter bit QUIET_IS_ONE = 1'b1
) (
    input  logic [W-1:0] value,
    output logic         is_nan,
    output logic         is_qnan,
    output logic         is_snan
);
    localparam int MAN_W = W - EXP_W - 1;
    localparam int QBIT  = MAN_W - 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    // Split the fields and decide the class.
    always_comb begin
        exp_f   = value[W-2 -: EXP_W];
        man_f   = value[MAN_W-1:0];
        is_nan  = (&exp_f) && (|man_f);
        is_qnan = is_nan && (man_f[QBIT] == QUIET_IS_ONE);
        is_snan = is_nan && (man_f[QBIT] != QUIET_IS_ONE);
    end
endmodule

// File: rtl/nanprop_select.sv
// Module: nanprop_select
// Chooses which operand a NaN result is built from, following the
// magnitude-select rules: NaN over number, quiet over signalling, larger
// significand among NaNs of one kind, positive operand on a tie.
// Assumes the class flags come from nanprop_classify.
module nanprop_select #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         a_qnan,
    input  logic         a_snan,
    input  logic         b_qnan,
    input  logic         b_snan,
    output logic         pick_b
);
    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    logic         a_wins;

    // Magnitude comparison with the sign shifted out; raw order breaks ties.
    always_comb begin
        mag_a = {op_a[W-2:0], 1'b0};
        mag_b = {op_b[W-2:0], 1'b0};
        if (mag_a > mag_b)
            a_wins = 1'b1;
        else if (mag_a < mag_b)
            a_wins = 1'b0;
        else
            a_wins = (op_a < op_b);
    end

    // Class-based priority, falling back to the magnitude decision.
    always_comb begin
        if (a_snan) begin
            if (b_snan)
                pick_b = !a_wins;
            else
                pick_b = b_qnan;
        end else if (a_qnan) begin
            if (b_qnan)
                pick_b = !a_wins;
            else
                pick_b = 1'b0;
        end else begin
            pick_b = 1'b1;
        end
    end
endmodule

// File: rtl/nanprop_resolve.sv
// Module: nanprop_resolve
// Turns the chosen operand into the final NaN under the active policy:
// quieting, replacement by the default NaN, or pass-through.
// Assumes chosen is a NaN whenever any operand is a NaN.
module nanprop_resolve
    import nanprop_pkg::*;
#(
    parameter int W            = 32,
    parameter int EXP_W        = 8,
    parameter bit QUIET_IS_ONE = 1'b1
) (
    input  logic [W-1:0] chosen,
    input  logic         chosen_snan,
    input  logic [1:0]   mode,
    output logic [W-1:0] nan_out
);
    localparam int MAN_W = W - EXP_W - 1;
    localparam int QBIT  = MAN_W - 1;
    localparam logic [MAN_W-1:0] DEF_MAN = QUIET_IS_ONE ?
        {1'b1, {QBIT{1'b0}}} : {1'b0, {QBIT{1'b1}}};
    localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, DEF_MAN};

    logic [W-1:0] quieted;
    logic         quiet_ok;
    np_mode_e     mode_e;

    generate
        if (QUIET_IS_ONE) begin : g_set_bit
            // Quieting sets the quiet bit; the significand stays non-zero.
            always_comb begin
                quieted       = chosen;
                quieted[QBIT] = 1'b1;
                quiet_ok      = 1'b1;
            end
        end else begin : g_clear_bit
            // Quieting clears the signalling bit; an empty significand is not a NaN.
            always_comb begin
                quieted       = chosen;
                quieted[QBIT] = 1'b0;
                quiet_ok      = |quieted[MAN_W-1:0];
            end
        end
    endgenerate

    // Apply the policy to the chosen operand.
    always_comb begin
        mode_e = np_mode_e'(mode);
        unique case (mode_e)
            NP_MODE_MAGSEL:   nan_out = chosen_snan ? (quiet_ok ? quieted : DEF_NAN) : chosen;
            NP_MODE_SNAN_DEF: nan_out = chosen_snan ? DEF_NAN : chosen;
            default:          nan_out = DEF_NAN;
        endcase
    end
endmodule

// File: rtl/nanprop_unit.sv
// Module: nanprop_unit (top)
// Registered NaN propagation for a two-operand operation. Classifies both
// operands, picks the source operand, resolves it under the mode, and
// registers result, NaN-present and invalid flags on valid_in.
// Assumes mode_in is stable with the operands in a valid_in cycle.
module nanprop_unit #(
    parameter bit IS_DOUBLE    = 1'b0,
    parameter bit QUIET_IS_ONE = 1'b1,
    localparam int W           = nanprop_pkg::fmt_width(IS_DOUBLE)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic [1:0]   mode_in,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         valid_out,
    output logic [W-1:0] result,
    output logic         nan_present,
    output logic         invalid
);
    localparam int EXP_W = nanprop_pkg::fmt_exp_width(IS_DOUBLE);
    localparam int MAN_W = W - EXP_W - 1;
    localparam int QBIT  = MAN_W - 1;
    localparam logic [MAN_W-1:0] DEF_MAN = QUIET_IS_ONE ?
        {1'b1, {QBIT{1'b0}}} : {1'b0, {QBIT{1'b1}}};
    localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, DEF_MAN};

    logic [W-1:0] ops   [2];
    logic [1:0]   is_nan;
    logic [1:0]   is_qnan;
    logic [1:0]   is_snan;
    logic         pick_b;
    logic [W-1:0] chosen;
    logic         chosen_snan;
    logic [W-1:0] nan_val;

    // Gather the operands for the classifier array.
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    generate
        for (genvar i = 0; i < 2; i++) begin : g_cls
            nanprop_classify #(
                .W(W), .EXP_W(EXP_W), .QUIET_IS_ONE(QUIET_IS_ONE)
            ) u_cls (
                .value  (ops[i]),
                .is_nan (is_nan[i]),
                .is_qnan(is_qnan[i]),
                .is_snan(is_snan[i])
            );
        end
    endgenerate

    nanprop_select #(.W(W)) u_sel (
        .op_a  (op_a),
        .op_b  (op_b),
        .a_qnan(is_qnan[0]),
        .a_snan(is_snan[0]),
        .b_qnan(is_qnan[1]),
        .b_snan(is_snan[1]),
        .pick_b(pick_b)
    );

    // Route the chosen operand and its class to the resolver.
    always_comb begin
        chosen      = pick_b ? op_b : op_a;
        chosen_snan = pick_b ? is_snan[1] : is_snan[0];
    end

    nanprop_resolve #(
        .W(W), .EXP_W(EXP_W), .QUIET_IS_ONE(QUIET_IS_ONE)
    ) u_res (
        .chosen     (chosen),
        .chosen_snan(chosen_snan),
        .mode       (mode_in),
        .nan_out    (nan_val)
    );

    // Output register stage: load on valid_in, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out   <= 1'b0;
            result      <= '0;
            nan_present <= 1'b0;
            invalid     <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                result      <= (|is_nan) ? nan_val : '0;
                nan_present <= |is_nan;
                invalid     <= |is_snan;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R11
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(result) && $stable(invalid)); // R11
    AST_NO_NAN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && !nan_present |-> result == '0 && !invalid); // R1
    AST_INVALID_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && invalid |-> nan_present); // R2
    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && nan_present |->
            (&result[W-2 -: EXP_W]) && (|result[MAN_W-1:0])
            && (result[QBIT] == QUIET_IS_ONE)); // R7
    AST_DEFAULT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && mode_in[1] && (op_a[W-2 -: EXP_W] == '1) && (|op_a[MAN_W-1:0])
            |=> result == DEF_NAN); // R9
endmodule

// File: tb/tb_nanprop_unit.sv
module tb_nanprop_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_in = 1'b0;
    logic [1:0] mode_in = 2'd0;
    logic [63:0] a64 = '0;
    logic [63:0] b64 = '0;
    logic [31:0] a32 = '0;
    logic [31:0] b32 = '0;
    logic        vo_s, np_s, inv_s, vo_d, np_d, inv_d;
    logic [31:0] res_s;
    logic [63:0] res_d;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // binary32, quiet bit means quiet
    nanprop_unit #(.IS_DOUBLE(1'b0), .QUIET_IS_ONE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode_in(mode_in),
        .op_a(a32), .op_b(b32), .valid_out(vo_s), .result(res_s),
        .nan_present(np_s), .invalid(inv_s));

    // binary64, quiet bit means signalling
    nanprop_unit #(.IS_DOUBLE(1'b1), .QUIET_IS_ONE(1'b0)) dut_alt (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode_in(mode_in),
        .op_a(a64), .op_b(b64), .valid_out(vo_d), .result(res_d),
        .nan_present(np_d), .invalid(inv_d));

    function automatic int mw_of(bit dbl); return dbl ? 52 : 23; endfunction
    function automatic int ew_of(bit dbl); return dbl ? 11 : 8;  endfunction

    function automatic logic [63:0] wmask(bit dbl);
        return dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    endfunction

    function automatic logic [63:0] def_nan(bit dbl, bit q1);
        int mw = mw_of(dbl);
        logic [63:0] e = ((64'd1 << ew_of(dbl)) - 1) << mw;
        return q1 ? (e | (64'd1 << (mw - 1))) : (e | ((64'd1 << (mw - 1)) - 1));
    endfunction

    // Build an operand of class cls: 0 number, 1 quiet NaN, 2 signalling NaN.
    function automatic logic [63:0] mk(bit dbl, bit q1, int cls, int pay, bit sgn);
        int mw = mw_of(dbl);
        int ew = ew_of(dbl);
        logic [63:0] man = 64'(pay);
        logic [63:0] ex;
        if (cls == 0) ex = 64'd3;
        else          ex = (64'd1 << ew) - 1;
        if (cls == 1) begin
            if (q1) man = man | (64'd1 << (mw - 1));
            else if (man == 0) man = 64'd1;
        end else if (cls == 2) begin
            if (!q1) man = man | (64'd1 << (mw - 1));
            else if (man == 0) man = 64'd1;
        end
        return (64'(sgn) << (ew + mw)) | (ex << mw) | man;
    endfunction

    function automatic bit f_nan(bit dbl, logic [63:0] x);
        int mw = mw_of(dbl);
        logic [63:0] e = (x >> mw) & ((64'd1 << ew_of(dbl)) - 1);
        return (e == ((64'd1 << ew_of(dbl)) - 1)) && ((x & ((64'd1 << mw) - 1)) != 0);
    endfunction

    function automatic bit f_snan(bit dbl, bit q1, logic [63:0] x);
        return f_nan(dbl, x) && (x[mw_of(dbl) - 1] != q1);
    endfunction

    // Reference result per the requirements: {nan_present, invalid, result}.
    function automatic logic [65:0] model(bit dbl, bit q1, logic [1:0] m,
                                          logic [63:0] a, logic [63:0] b);
        int mw = mw_of(dbl);
        bit an = f_nan(dbl, a), bn = f_nan(dbl, b);
        bit as_ = f_snan(dbl, q1, a), bs = f_snan(dbl, q1, b);
        bit aq = an && !as_, bq = bn && !bs;
        logic [63:0] am = (a << 1) & wmask(dbl);
        logic [63:0] bm = (b << 1) & wmask(dbl);
        bit alarge, pb, cs;
        logic [63:0] c, r;
        if (!an && !bn) return {2'b00, 64'd0};
        alarge = (am > bm) ? 1'b1 : (am < bm) ? 1'b0 : (a < b);
        if (as_)      pb = bs ? !alarge : bq;
        else if (aq)  pb = bq ? !alarge : 1'b0;
        else          pb = 1'b1;
        c  = pb ? b : a;
        cs = pb ? bs : as_;
        if (m[1]) r = def_nan(dbl, q1);
        else if (!cs) r = c;
        else if (m == 2'd1) r = def_nan(dbl, q1);
        else if (q1) r = c | (64'd1 << (mw - 1));
        else begin
            r = c & ~(64'd1 << (mw - 1));
            if ((r & ((64'd1 << mw) - 1)) == 0) r = def_nan(dbl, q1);
        end
        return {1'b1, as_ | bs, r};
    endfunction

    // Requirement tag for a result check.
    function automatic string rtag(bit q1, logic [1:0] m, int ca, int cb, bit tie);
        if (ca == 0 && cb == 0) return "R1";
        if (m[1]) return "R9";
        if (ca == 0 || cb == 0) begin
            if ((ca == 2 || cb == 2)) return (m == 2'd1) ? "R10" : (q1 ? "R7" : "R8");
            return "R3";
        end
        if (ca != cb) return "R4";
        if (m == 2'd1 && ca == 2) return "R10";
        return tie ? "R6" : "R5";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Drive one vector, then sample one cycle after the capturing edge.
    task automatic run_vec(logic [1:0] m, int ca, int cb, int pa, int pbv,
                           bit sa, bit sb);
        logic [65:0] es, ed;
        string tg_s, tg_d;
        bit tie = (pa == pbv);
        @(negedge clk);
        mode_in = m;
        a32 = mk(0, 1, ca, pa, sa) & 64'hFFFF_FFFF;
        b32 = mk(0, 1, cb, pbv, sb) & 64'hFFFF_FFFF;
        a64 = mk(1, 0, ca, pa, sa);
        b64 = mk(1, 0, cb, pbv, sb);
        valid_in = 1'b1;
        es = model(0, 1, m, {32'd0, a32}, {32'd0, b32});
        ed = model(1, 0, m, a64, b64);
        tg_s = rtag(1, m, ca, cb, tie);
        tg_d = rtag(0, m, ca, cb, tie);
        @(negedge clk);
        valid_in = 1'b0;
        chk("R11 valid_out", {63'd0, vo_s & vo_d}, 64'd1);
        chk("R1 nan_present", {62'd0, np_s, np_d}, {62'd0, es[65], ed[65]});
        chk("R2 invalid", {62'd0, inv_s, inv_d}, {62'd0, es[64], ed[64]});
        chk(tg_s, {32'd0, res_s}, es[63:0]);
        chk(tg_d, res_d, ed[63:0]);
    endtask

    initial begin
        int pa_t[6] = '{5, 9, 7, 7, 0, 6};
        int pb_t[6] = '{9, 5, 7, 7, 3, 6};
        bit sa_t[6] = '{0, 1, 1, 0, 0, 0};
        bit sb_t[6] = '{0, 0, 0, 1, 0, 0};
        logic [31:0] keep_s;
        logic [63:0] keep_d;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset", {res_s, 28'd0, vo_s, np_s, inv_s, vo_d}, 64'd0);
        chk("R11 reset alt", res_d | {63'd0, np_d | inv_d}, 64'd0);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++)
            for (int ca = 0; ca < 3; ca++)
                for (int cb = 0; cb < 3; cb++)
                    for (int v = 0; v < 6; v++)
                        run_vec(2'(m), ca, cb, pa_t[v], pb_t[v], sa_t[v], sb_t[v]);
        // R11: outputs hold while valid_in is low
        keep_s = res_s;
        keep_d = res_d;
        @(negedge clk);
        mode_in = 2'd2;
        a32 = 32'h7FA0_0000;
        a64 = 64'h7FF0_0000_0000_0001;
        valid_in = 1'b0;
        @(negedge clk);
        chk("R11 hold", {32'd0, res_s}, {32'd0, keep_s});
        chk("R11 hold alt", res_d, keep_d);
        chk("R11 idle valid", {62'd0, vo_s, vo_d}, 64'd0);
        // R9: exact default encodings
        run_vec(2'd2, 1, 0, 1, 0, 1, 0);
        chk("R9 default32", {32'd0, res_s}, 64'h7FC0_0000);
        chk("R9 default64", res_d, 64'h7FF7_FFFF_FFFF_FFFF);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule